// File: doc/BRIEF.md
# Lockstep Self-Checking Core Controller

This block supervises a self-checking computer module. A pair of identical processors runs in lockstep, and the controller compares their bus outputs on every cycle. It also checks parity on the shared internal bus whenever the processor pair owns that bus. It gathers two-wire fault indicators from the other building blocks of the module. Finally, it arbitrates ownership of the internal bus between the processor pair and the peripheral blocks.

Every fault is classified. A fault that persists, or that keeps returning, is treated as permanent. A permanent fault raises a sticky disable that takes the module offline: all bus grants are withdrawn. A short fault is logged as transient and does not disable the module. A status view reports three things: which source faulted first, the current fault class, and a saturating count of transient episodes. An external restart pulse clears the disable and all status. This pulse stands for a command that arrives through a bus adapter.

Top module: `lockstep_core_ctrl`

## Requirements
- R1: Whenever `lock_a` differs from `lock_b` in any bit, the controller sees a fault from source ID 0.
- R2: Bus parity is even, checked per 8-bit slice. Bit k of `bus_addr_par` is the XOR of `bus_addr[8k+7:8k]`, and bit k of `bus_data_par` is the XOR of `bus_data[8k+7:8k]`. A mismatch is a fault from source ID 1, but only in a cycle where `cpu_gnt` is 1 and `bus_busy` is 1. In any other cycle a bad parity bit has no effect on status.
- R3: Block i reports on `blk_flt[2i+1:2i]`. The code 01 means healthy and 10 means fault. The codes 00 and 11 mean a broken indicator, which is also a fault. Block i has source ID 2+i.
- R4: If any fault is present on 4 consecutive rising edges, `module_disable` is 1 after the 4th edge and `flt_class` reads 2'b10 (permanent). After only 3 such edges, the module is not disabled.
- R5: A fault onset is a fault-free edge followed by a faulty edge. A window opens at an onset when no window is open. The third onset within 255 edges after the opening onset makes the fault permanent and disables the module at that edge.
- R6: When a window has been open for 256 edges, it closes and its onset count is discarded. Three onsets spaced 130 edges apart therefore do not disable the module.
- R7: A fault episode ends on the edge after the last faulty edge. If the episode ended without a permanent verdict, `flt_tcount` increments (saturating) and `flt_class` reads 2'b01 (transient). `module_disable` stays 0.
- R8: `flt_first_src` holds the lowest ID among the sources that were active on the first faulty edge after reset or restart. Later faults do not change it.
- R9: Once set, `module_disable` stays 1 until restart. While it is 1, both grant outputs are 0 and new faults do not change the status.
- R10: A restart pulse clears `module_disable`, `flt_class`, `flt_tcount` and `flt_first_src` on the next edge.
- R11: Bus grants are one-hot or zero, and they update only on an edge where `bus_busy` is 0. Peripheral requests win over the processor pair and rotate round-robin, starting after the last peripheral granted. Peripheral 0 is first after reset. `cpu_gnt` is given only when no peripheral requests.
- R12: After reset, no grant is asserted, `module_disable` is 0, `flt_class` is 2'b00, `flt_tcount` is 0 and `flt_first_src` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_a | input | 36 | Bus outputs of processor A |
| lock_b | input | 36 | Bus outputs of processor B |
| bus_addr | input | 16 | Internal bus address field |
| bus_addr_par | input | 2 | Address slice parity |
| bus_data | input | 16 | Internal bus data field |
| bus_data_par | input | 2 | Data slice parity |
| bus_busy | input | 1 | Bus transfer in progress |
| cpu_req | input | 1 | Processor pair requests the bus |
| periph_req | input | 3 | Peripheral bus requests |
| cpu_gnt | output | 1 | Bus granted to processor pair |
| periph_gnt | output | 3 | Bus granted to a peripheral |
| blk_flt | input | 8 | Two-wire fault indicators, two bits per block |
| restart | input | 1 | Clears disable and fault status |
| module_disable | output | 1 | Sticky module disable |
| flt_first_src | output | 3 | ID of the first faulting source |
| flt_class | output | 2 | 00 none, 01 transient, 10 permanent |
| flt_tcount | output | 4 | Saturating transient episode count |

## Verification
Every result is registered, so it appears one rising edge after the edge that samples its cause. The bench changes inputs on falling edges and reads outputs on the following falling edge. Some results span several edges, and the bench counts those edges exactly before it reads. A persistent fault is read after its 3rd edge (not yet disabled) and again after its 4th edge (disabled). A transient is read one edge after the fault is removed. A grant is read one edge after an idle-bus cycle. The recurrence cases space their onsets by an exact number of edges, so that they fall just inside or just outside the 256-edge window.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic [1:0] {
    FC_NONE  = 2'b00,
    FC_TRANS = 2'b01,
    FC_PERM  = 2'b10
  } flt_class_e;
endpackage

// File: rtl/lsc_fault_collect.sv
module lsc_fault_collect #(
  parameter int CMP_W  = 36,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int PAR_W  = 2,
  parameter int NBLK   = 4,
  localparam int NSRC  = 2 + NBLK
) (
  input  logic [CMP_W-1:0]  lock_a,
  input  logic [CMP_W-1:0]  lock_b,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PAR_W-1:0]  bus_addr_par,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [PAR_W-1:0]  bus_data_par,
  input  logic              chk_en,
  input  logic [2*NBLK-1:0] blk_flt,
  output logic [NSRC-1:0]   flt_vec
);
  localparam int A_SL = ADDR_W / PAR_W;
  localparam int D_SL = DATA_W / PAR_W;

  logic            cmp_flt;
  logic            par_bad;
  logic [NBLK-1:0] dr_bad;

  assign cmp_flt = (lock_a != lock_b);

  // even parity per slice on both fields
  always_comb begin
    par_bad = 1'b0;
    for (int g = 0; g < PAR_W; g++) begin
      if ((^bus_addr[g*A_SL +: A_SL]) != bus_addr_par[g]) par_bad = 1'b1;
      if ((^bus_data[g*D_SL +: D_SL]) != bus_data_par[g]) par_bad = 1'b1;
    end
  end

  // two-wire indicators: only 01 is healthy
  for (genvar i = 0; i < NBLK; i++) begin : g_dr
    assign dr_bad[i] = (blk_flt[2*i +: 2] != 2'b01);
  end

  assign flt_vec = {dr_bad, chk_en & par_bad, cmp_flt};
endmodule

// File: rtl/lsc_fault_class.sv
module lsc_fault_class
  import lsc_pkg::*;
#(
  parameter int NSRC    = 6,
  parameter int SRC_W   = 3,
  parameter int PERSIST = 4,
  parameter int RECUR   = 3,
  parameter int WINDOW  = 256,
  parameter int TCNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [NSRC-1:0]   flt_vec,
  output logic              dis_o,
  output flt_class_e        cls_o,
  output logic [SRC_W-1:0]  src_o,
  output logic [TCNT_W-1:0] tcnt_o
);
  localparam int RUN_W = $clog2(PERSIST + 1);
  localparam int OCC_W = $clog2(RECUR + 1);
  localparam int WIN_W = $clog2(WINDOW);

  logic             prev_f, src_vld, win_open;
  logic [RUN_W-1:0] run_cnt;
  logic [OCC_W-1:0] occ;
  logic [WIN_W-1:0] win_cnt;
  logic [SRC_W-1:0] first_id;
  logic any_f, onset, ending, win_last, perm_run, perm_rec;

  assign any_f    = |flt_vec;
  assign onset    = any_f & ~prev_f;
  assign ending   = ~any_f & prev_f;
  assign win_last = win_open && (win_cnt == WIN_W'(WINDOW - 1));
  assign perm_run = any_f && (run_cnt == RUN_W'(PERSIST - 1));
  assign perm_rec = onset && win_open && !win_last && (occ == OCC_W'(RECUR - 1));

  // lowest active source ID
  always_comb begin
    first_id = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (flt_vec[i]) first_id = SRC_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_f <= 1'b0; run_cnt <= '0; occ <= '0; win_cnt <= '0; win_open <= 1'b0;
      dis_o <= 1'b0; cls_o <= FC_NONE; src_o <= '0; src_vld <= 1'b0; tcnt_o <= '0;
    end else if (restart) begin
      prev_f <= 1'b0; run_cnt <= '0; occ <= '0; win_cnt <= '0; win_open <= 1'b0;
      dis_o <= 1'b0; cls_o <= FC_NONE; src_o <= '0; src_vld <= 1'b0; tcnt_o <= '0;
    end else if (!dis_o) begin
      prev_f <= any_f;
      if (!any_f) run_cnt <= '0;
      else if (run_cnt != RUN_W'(PERSIST - 1)) run_cnt <= run_cnt + 1'b1;

      if (onset) begin
        if (!win_open || win_last) begin
          win_open <= 1'b1;
          win_cnt  <= '0;
          occ      <= OCC_W'(1);
        end else begin
          occ     <= occ + 1'b1;
          win_cnt <= win_cnt + 1'b1;
        end
      end else if (win_open) begin
        if (win_last) begin
          win_open <= 1'b0;
          win_cnt  <= '0;
          occ      <= '0;
        end else begin
          win_cnt <= win_cnt + 1'b1;
        end
      end

      if (perm_run || perm_rec) begin
        dis_o <= 1'b1;
        cls_o <= FC_PERM;
      end else if (ending) begin
        if (tcnt_o != '1) tcnt_o <= tcnt_o + 1'b1;
        cls_o <= FC_TRANS;
      end

      if (any_f && !src_vld) begin
        src_vld <= 1'b1;
        src_o   <= first_id;
      end
    end
  end
endmodule

// File: rtl/lsc_bus_arb.sv
module lsc_bus_arb #(
  parameter int NPERIPH = 3,
  localparam int PIDX_W = (NPERIPH > 1) ? $clog2(NPERIPH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_busy,
  input  logic               cpu_req,
  input  logic [NPERIPH-1:0] periph_req,
  output logic               cpu_gnt,
  output logic [NPERIPH-1:0] periph_gnt
);
  logic [PIDX_W-1:0] ptr, pick;
  logic              found;

  // search starts just after the last granted peripheral
  always_comb begin
    found = 1'b0;
    pick  = ptr;
    for (int k = 1; k <= NPERIPH; k++) begin
      int c;
      c = (int'(ptr) + k) % NPERIPH;
      if (!found && periph_req[c]) begin
        found = 1'b1;
        pick  = PIDX_W'(c);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr        <= PIDX_W'(NPERIPH - 1);
      cpu_gnt    <= 1'b0;
      periph_gnt <= '0;
    end else if (!bus_busy) begin
      if (found) begin
        periph_gnt <= NPERIPH'(1) << pick;
        ptr        <= pick;
        cpu_gnt    <= 1'b0;
      end else begin
        periph_gnt <= '0;
        cpu_gnt    <= cpu_req;
      end
    end
  end
endmodule

// File: rtl/lockstep_core_ctrl.sv
module lockstep_core_ctrl
  import lsc_pkg::*;
#(
  parameter int CMP_W   = 36,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int PAR_W   = 2,
  parameter int NPERIPH = 3,
  parameter int NBLK    = 4,
  parameter int PERSIST = 4,
  parameter int RECUR   = 3,
  parameter int WINDOW  = 256,
  parameter int TCNT_W  = 4,
  localparam int NSRC   = 2 + NBLK,
  localparam int SRC_W  = $clog2(NSRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CMP_W-1:0]   lock_a,
  input  logic [CMP_W-1:0]   lock_b,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [PAR_W-1:0]   bus_addr_par,
  input  logic [DATA_W-1:0]  bus_data,
  input  logic [PAR_W-1:0]   bus_data_par,
  input  logic               bus_busy,
  input  logic               cpu_req,
  input  logic [NPERIPH-1:0] periph_req,
  output logic               cpu_gnt,
  output logic [NPERIPH-1:0] periph_gnt,
  input  logic [2*NBLK-1:0]  blk_flt,
  input  logic               restart,
  output logic               module_disable,
  output logic [SRC_W-1:0]   flt_first_src,
  output logic [1:0]         flt_class,
  output logic [TCNT_W-1:0]  flt_tcount
);
  logic               cpu_gnt_r;
  logic [NPERIPH-1:0] periph_gnt_r;
  logic [NSRC-1:0]    flt_vec;
  logic               dis;
  flt_class_e         cls;

  lsc_bus_arb #(.NPERIPH(NPERIPH)) u_arb (
    .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy), .cpu_req(cpu_req),
    .periph_req(periph_req), .cpu_gnt(cpu_gnt_r), .periph_gnt(periph_gnt_r)
  );

  lsc_fault_collect #(
    .CMP_W(CMP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAR_W(PAR_W), .NBLK(NBLK)
  ) u_collect (
    .lock_a(lock_a), .lock_b(lock_b), .bus_addr(bus_addr), .bus_addr_par(bus_addr_par),
    .bus_data(bus_data), .bus_data_par(bus_data_par), .chk_en(cpu_gnt_r & bus_busy),
    .blk_flt(blk_flt), .flt_vec(flt_vec)
  );

  lsc_fault_class #(
    .NSRC(NSRC), .SRC_W(SRC_W), .PERSIST(PERSIST), .RECUR(RECUR),
    .WINDOW(WINDOW), .TCNT_W(TCNT_W)
  ) u_class (
    .clk(clk), .rst_n(rst_n), .restart(restart), .flt_vec(flt_vec),
    .dis_o(dis), .cls_o(cls), .src_o(flt_first_src), .tcnt_o(flt_tcount)
  );

  assign module_disable = dis;
  assign flt_class      = cls;
  assign cpu_gnt        = cpu_gnt_r & ~dis;
  assign periph_gnt     = periph_gnt_r & {NPERIPH{~dis}};
endmodule

// File: rtl/lsc_checker.sv
module lsc_checker #(
  parameter int NPERIPH = 3,
  parameter int TCNT_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               restart,
  input logic               bus_busy,
  input logic               cpu_gnt,
  input logic [NPERIPH-1:0] periph_gnt,
  input logic               module_disable,
  input logic [1:0]         flt_class,
  input logic [TCNT_W-1:0]  flt_tcount
);
  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_gnt, periph_gnt})); // R11
  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && !module_disable) |=> (module_disable || $stable({cpu_gnt, periph_gnt}))); // R11
  AST_DIS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (module_disable && !restart) |=> module_disable); // R9
  AST_DIS_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    module_disable |-> ({cpu_gnt, periph_gnt} == '0)); // R9
  AST_DIS_PERM: assert property (@(posedge clk) disable iff (!rst_n)
    module_disable |-> (flt_class == 2'b10)); // R4
  AST_RESTART_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!module_disable && flt_class == 2'b00 && flt_tcount == '0)); // R10
  AST_TCOUNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> (flt_tcount >= $past(flt_tcount))); // R7
endmodule

bind lockstep_core_ctrl lsc_checker #(.NPERIPH(NPERIPH), .TCNT_W(TCNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart), .bus_busy(bus_busy),
  .cpu_gnt(cpu_gnt), .periph_gnt(periph_gnt), .module_disable(module_disable),
  .flt_class(flt_class), .flt_tcount(flt_tcount)
);

// File: tb/lockstep_core_ctrl_tb.sv
`timescale 1ns/1ps
module lockstep_core_ctrl_tb;
  localparam int NP = 3;
  localparam int NB = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [35:0] lock_a = '0, lock_b = '0;
  logic [15:0] bus_addr = '0, bus_data = '0;
  logic [1:0]  bus_addr_par = '0, bus_data_par = '0;
  logic        bus_busy = 1'b0, cpu_req = 1'b0, restart = 1'b0;
  logic [NP-1:0] periph_req = '0;
  logic [2*NB-1:0] blk_flt = {NB{2'b01}};
  logic        cpu_gnt, module_disable;
  logic [NP-1:0] periph_gnt;
  logic [2:0]  flt_first_src;
  logic [1:0]  flt_class;
  logic [3:0]  flt_tcount;

  int vecs = 0;
  int errs = 0;

  always #2.5 clk = ~clk;

  lockstep_core_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .lock_a(lock_a), .lock_b(lock_b),
    .bus_addr(bus_addr), .bus_addr_par(bus_addr_par), .bus_data(bus_data),
    .bus_data_par(bus_data_par), .bus_busy(bus_busy), .cpu_req(cpu_req),
    .periph_req(periph_req), .cpu_gnt(cpu_gnt), .periph_gnt(periph_gnt),
    .blk_flt(blk_flt), .restart(restart), .module_disable(module_disable),
    .flt_first_src(flt_first_src), .flt_class(flt_class), .flt_tcount(flt_tcount)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [1:0] par16(input logic [15:0] v);
    return {^v[15:8], ^v[7:0]};
  endfunction

  task automatic do_restart();
    restart = 1'b1; cyc(1); restart = 1'b0;
  endtask

  task automatic mismatch_pulse();
    lock_b = 36'h1; cyc(1); lock_b = '0;
  endtask

  task automatic t_reset();
    check("R12 disable", module_disable, 0);
    check("R12 class", flt_class, 0);
    check("R12 tcount", flt_tcount, 0);
    check("R12 src", flt_first_src, 0);
    check("R12 grants", {cpu_gnt, periph_gnt}, 0);
  endtask

  task automatic t_arb();
    periph_req = 3'b111; cpu_req = 1'b1;
    cyc(1); check("R11 rr first p0", {cpu_gnt, periph_gnt}, 4'b0001);
    cyc(1); check("R11 rr p1", {cpu_gnt, periph_gnt}, 4'b0010);
    cyc(1); check("R11 rr p2", {cpu_gnt, periph_gnt}, 4'b0100);
    cyc(1); check("R11 rr wrap p0", {cpu_gnt, periph_gnt}, 4'b0001);
    bus_busy = 1'b1;
    cyc(3); check("R11 hold while busy", {cpu_gnt, periph_gnt}, 4'b0001);
    bus_busy = 1'b0; periph_req = '0;
    cyc(1); check("R11 cpu lowest", {cpu_gnt, periph_gnt}, 4'b1000);
    periph_req = 3'b100;
    cyc(1); check("R11 periph beats cpu", {cpu_gnt, periph_gnt}, 4'b0100);
    periph_req = '0; cpu_req = 1'b0;
    cyc(1); check("R11 none", {cpu_gnt, periph_gnt}, 4'b0000);
  endtask

  task automatic t_transient();
    mismatch_pulse();
    cyc(1);
    check("R7 class transient", flt_class, 2'b01);
    check("R7 tcount", flt_tcount, 1);
    check("R7 no disable", module_disable, 0);
    check("R1 src compare", flt_first_src, 0);
    do_restart();
  endtask

  task automatic t_persist();
    lock_b = 36'h8_0000_0000;
    cyc(3); check("R4 not yet after 3", module_disable, 0);
    cyc(1); check("R4 disable after 4", module_disable, 1);
    check("R4 class perm", flt_class, 2'b10);
    check("R1 src", flt_first_src, 0);
    lock_b = '0;
    periph_req = 3'b001;
    cyc(5); check("R9 sticky", module_disable, 1);
    check("R9 grants off", {cpu_gnt, periph_gnt}, 0);
    blk_flt[1:0] = 2'b10; cyc(1); blk_flt[1:0] = 2'b01; cyc(2);
    check("R9 frozen tcount", flt_tcount, 0);
    check("R9 frozen src", flt_first_src, 0);
    do_restart();
    check("R10 disable clr", module_disable, 0);
    check("R10 class clr", flt_class, 0);
    check("R10 grant back", periph_gnt, 3'b001);
    periph_req = '0; cyc(1);
  endtask

  task automatic t_dualrail();
    logic [1:0] codes [3];
    codes[0] = 2'b10; codes[1] = 2'b00; codes[2] = 2'b11;
    for (int c = 0; c < 3; c++) begin
      blk_flt[5:4] = codes[c]; cyc(1); blk_flt[5:4] = 2'b01; cyc(1);
      check("R3 block2 src", flt_first_src, 4);
      check("R3 block2 class", flt_class, 2'b01);
      do_restart();
    end
    blk_flt[7:6] = 2'b10; blk_flt[3:2] = 2'b11; cyc(1);
    blk_flt = {NB{2'b01}}; lock_b = 36'h2; cyc(1); lock_b = '0; cyc(1);
    check("R8 lowest of first edge", flt_first_src, 3);
    check("R8 tcount one episode", flt_tcount, 1);
    do_restart();
  endtask

  task automatic t_parity();
    cpu_req = 1'b1; cyc(1);
    check("R11 cpu grant", cpu_gnt, 1);
    bus_addr = 16'h1234; bus_data = 16'h00A5;
    bus_addr_par = par16(16'h1234); bus_data_par = par16(16'h00A5);
    bus_busy = 1'b1; cyc(2);
    check("R2 good parity", flt_class, 0);
    bus_data_par[1] = ~bus_data_par[1]; cyc(1);
    bus_data_par = par16(16'h00A5); bus_busy = 1'b0; cyc(1);
    check("R2 bad parity class", flt_class, 2'b01);
    check("R2 parity src", flt_first_src, 1);
    do_restart();
    bus_addr_par[0] = ~bus_addr_par[0]; cyc(2);
    check("R2 ignored when idle", flt_class, 0);
    cpu_req = 1'b0; periph_req = 3'b010; cyc(1);
    check("R2 peripheral master", cpu_gnt, 0);
    bus_busy = 1'b1; cyc(2); bus_busy = 1'b0; cyc(1);
    check("R2 ignored for peripheral", flt_class, 0);
    check("R2 ignored tcount", flt_tcount, 0);
    bus_addr_par = par16(16'h1234); periph_req = '0; cyc(1);
  endtask

  task automatic t_recur();
    mismatch_pulse(); cyc(8);
    mismatch_pulse(); cyc(8);
    check("R5 two onsets no disable", module_disable, 0);
    mismatch_pulse();
    check("R5 third onset disables", module_disable, 1);
    check("R5 tcount", flt_tcount, 2);
    do_restart();
  endtask

  task automatic t_spread();
    mismatch_pulse(); cyc(129);
    mismatch_pulse(); cyc(129);
    mismatch_pulse(); cyc(1);
    check("R6 spread no disable", module_disable, 0);
    check("R6 tcount", flt_tcount, 3);
    check("R6 class", flt_class, 2'b01);
    do_restart();
  endtask

  initial begin
    #1000000;
    errs++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_arb();
    t_transient();
    t_persist();
    t_dualrail();
    t_parity();
    t_recur();
    t_spread();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule